// File: doc/BRIEF.md
# Signed Multiply-Accumulate Unit with Rounded Readout

This block is the multiply-accumulate datapath that sits beside a processor's execute stage. Each cycle it can take one command together with two 32-bit signed operands. A multiply command picks which halves of the operands to multiply: high by high, low by low, or the full first operand by either half of the second. The product is then aligned and either replaces a 56-bit accumulator or is added to it. Multiply commands produce no result at the output.

Readout commands return accumulator contents as a 32-bit word for the register file. A readout can round the accumulator to 32-bit or 16-bit precision with saturation. It can shift the accumulator left by up to two places and take a 32-bit window. It can also return the raw upper or lower part. A load command places a register value into the accumulator. Every command completes in one cycle, and readout results appear on a registered output one cycle after the command.

Top module: `mac_unit`

## Requirements
- R1: A synchronous active-high reset clears the accumulator to zero, drives `res_o` to zero and holds `res_vld_o` low.
- R2: `op_sel` 0 overwrites the accumulator with the product of the signed upper 16 bits of A and B. `op_sel` 1 does the same with the signed lower 16 bits. The 32-bit product is shifted left by 16 and sign-extended to 56 bits.
- R3: `op_sel` 2 overwrites the accumulator with the full signed 32-bit A times the signed upper 16 bits of B. `op_sel` 3 uses the signed lower 16 bits of B instead. The 48-bit product is sign-extended to 56 bits without a shift.
- R4: `op_sel` 4 to 7 form the same products as modes 0 to 3 (mode = `op_sel[1:0]`) and add them to the accumulator, wrapping modulo 2^56 with no saturation.
- R5: A command is accepted on every cycle in which `op_go` is high. For each readout command (`op_sel` 8 to 12), `res_o` carries the value computed from the accumulator as it stood before that cycle's edge, and `res_vld_o` is high for exactly the following cycle. No other command raises `res_vld_o`.
- R6: `op_sel` 8 adds 2^15 to the accumulator and returns bits 47:16 of the sum. When the value does not fit the signed 32-bit range, it returns 0x7FFFFFFF or 0x80000000 instead.
- R7: `op_sel` 9 adds 2^31 to the accumulator and returns bits 47:32 of the sum, sign-extended to 32 bits. When the value does not fit the signed 16-bit range, it returns 0x00007FFF or 0xFFFF8000 instead.
- R8: `op_sel` 10 shifts the accumulator left by `shamt_i` places, with a value of 3 treated as 2, and returns bits 47:16 of the shifted value.
- R9: `op_sel` 11 returns accumulator bits 55:32 sign-extended to 32 bits. `op_sel` 12 returns bits 31:0.
- R10: `op_sel` 13 loads the accumulator with A sign-extended, placed at bits 47:16, with bits 15:0 cleared.
- R11: Readout commands, the unused codes 14 and 15, and cycles with `op_go` low leave the accumulator unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_go | input | 1 | Command strobe, one command per cycle |
| op_sel | input | 4 | Command code |
| opa_i | input | 32 | Operand A (signed) |
| opb_i | input | 32 | Operand B (signed) |
| shamt_i | input | 2 | Left-shift amount for the shift readout |
| res_o | output | 32 | Registered readout result |
| res_vld_o | output | 1 | High for the cycle in which `res_o` holds a new result |

## Verification
The bench tries each multiply mode with operands whose upper and lower halves differ in sign and size. A swapped half, a dropped shift or a missing sign extension therefore shows up in the raw upper and lower readouts. A run of 512 back-to-back accumulates of the largest positive product drives the accumulator across its top bit. That run separates wrapping from saturating accumulation and also tests the saturation limits of both rounding widths in each direction. Small products placed just at and around the rounding bit separate round-half-up from truncation. A loaded pattern read at every shift amount, including the clamped code 3, shows the window position. Reserved codes and idle cycles that carry live operands, followed by readouts, show that the accumulator was not touched.

// File: rtl/mac_pkg.sv
package mac_pkg;

  // Command codes on op_sel
  typedef enum logic [3:0] {
    OP_MUL_HH  = 4'd0,
    OP_MUL_LL  = 4'd1,
    OP_MUL_WH  = 4'd2,
    OP_MUL_WL  = 4'd3,
    OP_MAC_HH  = 4'd4,
    OP_MAC_LL  = 4'd5,
    OP_MAC_WH  = 4'd6,
    OP_MAC_WL  = 4'd7,
    OP_RND_W   = 4'd8,
    OP_RND_H   = 4'd9,
    OP_SHIFT   = 4'd10,
    OP_RD_UP   = 4'd11,
    OP_RD_DN   = 4'd12,
    OP_LOAD    = 4'd13,
    OP_RSVD_E  = 4'd14,
    OP_RSVD_F  = 4'd15
  } mac_op_e;

  // Readout flavours
  typedef enum logic [2:0] {
    RK_RND_W = 3'd0,
    RK_RND_H = 3'd1,
    RK_SHIFT = 3'd2,
    RK_UP    = 3'd3,
    RK_DN    = 3'd4
  } rd_kind_e;

  // Accumulator update flavours
  typedef enum logic [1:0] {
    AU_HOLD = 2'd0,
    AU_SET  = 2'd1,
    AU_ADD  = 2'd2,
    AU_LOAD = 2'd3
  } acc_upd_e;

endpackage

// File: rtl/mac_op_decode.sv
module mac_op_decode
  import mac_pkg::*;
(
  input  logic       op_go,
  input  logic [3:0] op_sel,
  output acc_upd_e   acc_upd,
  output logic [1:0] mul_mode,
  output logic       rd_en,
  output rd_kind_e   rd_kind
);

  assign mul_mode = op_sel[1:0];

  always_comb begin
    acc_upd = AU_HOLD;
    rd_en   = 1'b0;
    rd_kind = RK_DN;
    if (op_go) begin
      unique case (mac_op_e'(op_sel))
        OP_MUL_HH, OP_MUL_LL, OP_MUL_WH, OP_MUL_WL: acc_upd = AU_SET;
        OP_MAC_HH, OP_MAC_LL, OP_MAC_WH, OP_MAC_WL: acc_upd = AU_ADD;
        OP_LOAD:  acc_upd = AU_LOAD;
        OP_RND_W: begin rd_en = 1'b1; rd_kind = RK_RND_W; end
        OP_RND_H: begin rd_en = 1'b1; rd_kind = RK_RND_H; end
        OP_SHIFT: begin rd_en = 1'b1; rd_kind = RK_SHIFT; end
        OP_RD_UP: begin rd_en = 1'b1; rd_kind = RK_UP;    end
        OP_RD_DN: begin rd_en = 1'b1; rd_kind = RK_DN;    end
        default:  acc_upd = AU_HOLD;
      endcase
    end
  end

endmodule

// File: rtl/mac_prod_align.sv
module mac_prod_align #(
  parameter int OP_W  = 32,
  parameter int ACC_W = 56
) (
  input  logic [OP_W-1:0]  opa_i,
  input  logic [OP_W-1:0]  opb_i,
  input  logic [1:0]       mode_i,
  output logic [ACC_W-1:0] prod_o
);

  localparam int HALF_W = OP_W / 2;
  localparam int NARROW_W = 2 * HALF_W;
  localparam int WIDE_W = OP_W + HALF_W;
  localparam int EXT_W = ACC_W - WIDE_W;

  logic signed [HALF_W-1:0]   a_hi, a_lo, b_hi, b_lo;
  logic signed [OP_W-1:0]     a_full;
  logic signed [NARROW_W-1:0] p_nar;
  logic signed [WIDE_W-1:0]   p_wide;
  logic        [WIDE_W-1:0]   aligned;

  assign a_hi   = opa_i[OP_W-1:HALF_W];
  assign a_lo   = opa_i[HALF_W-1:0];
  assign b_hi   = opb_i[OP_W-1:HALF_W];
  assign b_lo   = opb_i[HALF_W-1:0];
  assign a_full = opa_i;

  // 16x16 product: pick halves of both operands
  assign p_nar  = mode_i[0] ? (a_lo * b_lo) : (a_hi * b_hi);
  // 32x16 product: full A against one half of B
  assign p_wide = a_full * (mode_i[0] ? b_lo : b_hi);

  // Narrow product moves up by half a word; wide product stays put
  assign aligned = mode_i[1] ? p_wide : {p_nar, {HALF_W{1'b0}}};

  assign prod_o = {{EXT_W{aligned[WIDE_W-1]}}, aligned};

endmodule

// File: rtl/mac_round.sv
module mac_round #(
  parameter int ACC_W   = 56,
  parameter int OP_W    = 32,
  parameter int RND_POS = 15,
  parameter int OUT_LSB = 16,
  parameter int OUT_W   = 32
) (
  input  logic [ACC_W-1:0] acc_i,
  output logic [OP_W-1:0]  res_o
);

  localparam int EXT_W  = ACC_W + 1;
  localparam int OUT_MSB = OUT_LSB + OUT_W - 1;
  localparam int TOP_W  = EXT_W - OUT_MSB;

  logic [EXT_W-1:0] sum;
  logic [TOP_W-1:0] top_bits;
  logic             fits;
  logic [OUT_W-1:0] val;

  assign sum      = {acc_i[ACC_W-1], acc_i} + (EXT_W'(1) << RND_POS);
  assign top_bits = sum[EXT_W-1:OUT_MSB];
  assign fits     = (top_bits == '0) || (top_bits == '1);

  always_comb begin
    if (fits)
      val = sum[OUT_MSB:OUT_LSB];
    else if (sum[EXT_W-1])
      val = {1'b1, {(OUT_W-1){1'b0}}};
    else
      val = {1'b0, {(OUT_W-1){1'b1}}};
  end

  generate
    if (OUT_W == OP_W) begin : g_full
      assign res_o = val;
    end else begin : g_sext
      assign res_o = {{(OP_W-OUT_W){val[OUT_W-1]}}, val};
    end
  endgenerate

endmodule

// File: rtl/mac_readout.sv
module mac_readout
  import mac_pkg::*;
#(
  parameter int OP_W   = 32,
  parameter int ACC_W  = 56,
  parameter int MAX_SH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  rd_kind_e         rd_kind,
  input  logic [1:0]       shamt_i,
  input  logic [ACC_W-1:0] acc_i,
  output logic [OP_W-1:0]  res_o,
  output logic             res_vld_o
);

  localparam int HALF_W  = OP_W / 2;
  localparam int WIN_LO  = HALF_W;
  localparam int WIN_HI  = OP_W + HALF_W - 1;
  localparam int UP_W    = ACC_W - OP_W;

  logic [OP_W-1:0]  rnd_w, rnd_h, rd_val;
  logic [1:0]       sh_eff;
  logic [ACC_W-1:0] shifted;

  mac_round #(
    .ACC_W(ACC_W), .OP_W(OP_W),
    .RND_POS(HALF_W - 1), .OUT_LSB(HALF_W), .OUT_W(OP_W)
  ) i_rnd_w (
    .acc_i(acc_i), .res_o(rnd_w)
  );

  mac_round #(
    .ACC_W(ACC_W), .OP_W(OP_W),
    .RND_POS(OP_W - 1), .OUT_LSB(OP_W), .OUT_W(HALF_W)
  ) i_rnd_h (
    .acc_i(acc_i), .res_o(rnd_h)
  );

  assign sh_eff  = (32'(shamt_i) > MAX_SH) ? 2'(MAX_SH) : shamt_i;
  assign shifted = acc_i << sh_eff;

  always_comb begin
    unique case (rd_kind)
      RK_RND_W: rd_val = rnd_w;
      RK_RND_H: rd_val = rnd_h;
      RK_SHIFT: rd_val = shifted[WIN_HI:WIN_LO];
      RK_UP:    rd_val = {{(OP_W-UP_W){acc_i[ACC_W-1]}}, acc_i[ACC_W-1:OP_W]};
      default:  rd_val = acc_i[OP_W-1:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o     <= '0;
      res_vld_o <= 1'b0;
    end else begin
      res_vld_o <= rd_en;
      if (rd_en) res_o <= rd_val;
    end
  end

  // R5: a readout command yields a valid result on the next cycle
  p_vld_after_read_r5: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> res_vld_o);

  // R5: no valid result without a readout command in the cycle before
  p_vld_only_read_r5: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !res_vld_o);

  // R7: a 16-bit rounded result always lies in the signed 16-bit range
  p_rnd_h_range_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_en) && !$past(rst) && ($past(rd_kind) == RK_RND_H))
      |-> ((res_o[OP_W-1:HALF_W-1] == '0) || (res_o[OP_W-1:HALF_W-1] == '1)));

endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int OP_W   = 32,
  parameter int ACC_W  = 56,
  parameter int MAX_SH = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            op_go,
  input  logic [3:0]      op_sel,
  input  logic [OP_W-1:0] opa_i,
  input  logic [OP_W-1:0] opb_i,
  input  logic [1:0]      shamt_i,
  output logic [OP_W-1:0] res_o,
  output logic            res_vld_o
);

  localparam int HALF_W = OP_W / 2;
  localparam int LD_EXT = ACC_W - OP_W - HALF_W;

  acc_upd_e         acc_upd;
  logic [1:0]       mul_mode;
  logic             rd_en;
  rd_kind_e         rd_kind;
  logic [ACC_W-1:0] prod;
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] load_val;

  mac_op_decode i_dec (
    .op_go(op_go), .op_sel(op_sel),
    .acc_upd(acc_upd), .mul_mode(mul_mode),
    .rd_en(rd_en), .rd_kind(rd_kind)
  );

  mac_prod_align #(.OP_W(OP_W), .ACC_W(ACC_W)) i_prod (
    .opa_i(opa_i), .opb_i(opb_i), .mode_i(mul_mode), .prod_o(prod)
  );

  assign load_val = {{LD_EXT{opa_i[OP_W-1]}}, opa_i, {HALF_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
    end else begin
      unique case (acc_upd)
        AU_SET:  acc_q <= prod;
        AU_ADD:  acc_q <= acc_q + prod;
        AU_LOAD: acc_q <= load_val;
        default: acc_q <= acc_q;
      endcase
    end
  end

  mac_readout #(.OP_W(OP_W), .ACC_W(ACC_W), .MAX_SH(MAX_SH)) i_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_kind(rd_kind),
    .shamt_i(shamt_i), .acc_i(acc_q),
    .res_o(res_o), .res_vld_o(res_vld_o)
  );

  // R1: reset leaves the accumulator cleared and no result pending
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (acc_q == '0) && !res_vld_o);

  // R11: idle cycles keep the accumulator
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !op_go |=> $stable(acc_q));

  // R11: readout and reserved codes keep the accumulator
  p_read_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (op_go && op_sel[3] && (op_sel != 4'd13)) |=> $stable(acc_q));

  // R10: a load leaves the low half-word of the accumulator cleared
  p_load_low_r10: assert property (@(posedge clk) disable iff (rst)
    (op_go && (op_sel == 4'd13)) |=> (acc_q[HALF_W-1:0] == '0));

endmodule

// File: tb/test_mac_unit.sv
`timescale 1ns/1ps
module test_mac_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_go = 1'b0;
  logic [3:0]  op_sel = 4'd0;
  logic [31:0] opa = '0;
  logic [31:0] opb = '0;
  logic [1:0]  shamt = '0;
  logic [31:0] res;
  logic        res_vld;

  always #2 clk = ~clk;

  mac_unit i_mac_unit (
    .clk(clk), .rst(rst), .op_go(op_go), .op_sel(op_sel),
    .opa_i(opa), .opb_i(opb), .shamt_i(shamt),
    .res_o(res), .res_vld_o(res_vld)
  );

  typedef struct {
    logic [31:0] val;
    string       tag;
  } exp_t;

  exp_t   sbq[$];
  int     n_chk = 0;
  int     n_err = 0;
  longint m_acc = 0;

  function automatic longint wrap56(longint v);
    return (v <<< 8) >>> 8;
  endfunction

  function automatic longint clamp(longint v, int w);
    longint hi = (longint'(1) <<< (w - 1)) - 1;
    longint lo = -(longint'(1) <<< (w - 1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  function automatic longint prod(logic [1:0] m, logic [31:0] a, logic [31:0] b);
    case (m)
      2'd0: return (longint'($signed(a[31:16])) * longint'($signed(b[31:16]))) * 65536;
      2'd1: return (longint'($signed(a[15:0])) * longint'($signed(b[15:0]))) * 65536;
      2'd2: return longint'($signed(a)) * longint'($signed(b[31:16]));
      default: return longint'($signed(a)) * longint'($signed(b[15:0]));
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic push(input longint v, input string tag);
    exp_t e;
    e.val = v[31:0];
    e.tag = tag;
    sbq.push_back(e);
  endtask

  // Driver: issue one command and update the reference model
  task automatic do_op(input logic [3:0] sel, input logic [31:0] a, input logic [31:0] b,
                       input logic [1:0] sh, input string tag);
    longint t;
    @(negedge clk);
    op_go = 1'b1; op_sel = sel; opa = a; opb = b; shamt = sh;
    case (sel)
      4'd0, 4'd1, 4'd2, 4'd3: m_acc = wrap56(prod(sel[1:0], a, b));
      4'd4, 4'd5, 4'd6, 4'd7: m_acc = wrap56(m_acc + prod(sel[1:0], a, b));
      4'd8:  push(clamp((m_acc + 32768) >>> 16, 32), tag);
      4'd9:  push(clamp((m_acc + (longint'(1) <<< 31)) >>> 32, 16), tag);
      4'd10: begin
        t = wrap56(m_acc <<< ((sh == 2'd3) ? 2 : int'(sh)));
        push(t >>> 16, tag);
      end
      4'd11: push(m_acc >>> 32, tag);
      4'd12: push(m_acc, tag);
      4'd13: m_acc = longint'($signed(a)) * 65536;
      default: ;
    endcase
  endtask

  task automatic idle(input logic [3:0] sel, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    op_go = 1'b0; op_sel = sel; opa = a; opb = b;
  endtask

  task automatic read_both(input string tag);
    do_op(4'd11, 32'h0, 32'h0, 2'd0, tag);
    do_op(4'd12, 32'h0, 32'h0, 2'd0, tag);
  endtask

  // Monitor: compare each valid result against the scoreboard
  always @(negedge clk) begin
    if (!rst && res_vld) begin
      if (sbq.size() == 0) begin
        check(1'b0, "R5 unexpected valid", res, 32'h0);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        check(res === e.val, e.tag, res, e.val);
      end
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state at the ports
    check(res === 32'h0, "R1 res after reset", res, 32'h0);
    check(res_vld === 1'b0, "R1 valid after reset", {31'h0, res_vld}, 32'h0);
    read_both("R1 acc after reset");

    // R2: 16x16 modes, halves of opposite sign
    do_op(4'd0, 32'h0003_1111, 32'hFFFE_2222, 2'd0, "R2");
    read_both("R2/R9 mode0");
    do_op(4'd1, 32'h1234_8001, 32'h5678_7FFF, 2'd0, "R2");
    read_both("R2/R9 mode1");

    // R3: 32x16 modes
    do_op(4'd2, 32'h8000_0000, 32'h7FFF_0000, 2'd0, "R3");
    read_both("R3/R9 mode2");
    do_op(4'd3, 32'h1234_5678, 32'h0000_FFFF, 2'd0, "R3");
    read_both("R3/R9 mode3");

    // R4/R5: 512 back-to-back accumulates wrap the accumulator
    do_op(4'd13, 32'h0, 32'h0, 2'd0, "R10");
    for (int i = 0; i < 512; i++)
      do_op(4'd4, 32'h8000_0000, 32'h8000_0000, 2'd0, "R4");
    read_both("R4 wrap");
    do_op(4'd8, 32'h0, 32'h0, 2'd0, "R6 sat neg");
    do_op(4'd9, 32'h0, 32'h0, 2'd0, "R7 sat neg");

    // R6/R7: positive saturation
    do_op(4'd0, 32'h8000_0000, 32'h8000_0000, 2'd0, "R2");
    for (int i = 0; i < 510; i++)
      do_op(4'd4, 32'h8000_0000, 32'h8000_0000, 2'd0, "R4");
    do_op(4'd8, 32'h0, 32'h0, 2'd0, "R6 sat pos");
    do_op(4'd9, 32'h0, 32'h0, 2'd0, "R7 sat pos");

    // R6: rounding around bit 15
    do_op(4'd3, 32'h0000_8000, 32'h0000_0001, 2'd0, "R3");
    do_op(4'd8, 32'h0, 32'h0, 2'd0, "R6 half up");
    do_op(4'd3, 32'h0000_7FFF, 32'h0000_0001, 2'd0, "R3");
    do_op(4'd8, 32'h0, 32'h0, 2'd0, "R6 below half");
    do_op(4'd3, 32'hFFFF_8000, 32'h0000_0001, 2'd0, "R3");
    do_op(4'd8, 32'h0, 32'h0, 2'd0, "R6 neg half");
    do_op(4'd3, 32'hFFFF_7FFF, 32'h0000_0001, 2'd0, "R3");
    do_op(4'd8, 32'h0, 32'h0, 2'd0, "R6 neg below");

    // R7: rounding around bit 31
    do_op(4'd3, 32'h4000_0000, 32'h0000_0002, 2'd0, "R3");
    do_op(4'd9, 32'h0, 32'h0, 2'd0, "R7 half up");
    do_op(4'd3, 32'h3FFF_FFFF, 32'h0000_0002, 2'd0, "R3");
    do_op(4'd9, 32'h0, 32'h0, 2'd0, "R7 below half");

    // R10/R8: load then shifted readout at every amount
    do_op(4'd13, 32'h1234_5678, 32'h0, 2'd0, "R10");
    read_both("R10 load pos");
    for (int k = 0; k < 4; k++)
      do_op(4'd10, 32'h0, 32'h0, 2'(k), "R8 shift");
    do_op(4'd13, 32'h8765_4321, 32'h0, 2'd0, "R10");
    read_both("R10 load neg");
    do_op(4'd10, 32'h0, 32'h0, 2'd1, "R8 shift neg");
    do_op(4'd8, 32'h0, 32'h0, 2'd0, "R6 loaded");
    do_op(4'd9, 32'h0, 32'h0, 2'd0, "R7 loaded");

    // R11: reserved codes, idle cycles and readouts leave the accumulator
    do_op(4'd2, 32'h7654_3210, 32'h0123_4567, 2'd0, "R3");
    do_op(4'd14, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'd0, "R11");
    do_op(4'd15, 32'h1111_1111, 32'h2222_2222, 2'd0, "R11");
    idle(4'd4, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
    idle(4'd13, 32'h5555_5555, 32'h0);
    do_op(4'd8, 32'h0, 32'h0, 2'd0, "R11 after reserved");
    do_op(4'd10, 32'h0, 32'h0, 2'd2, "R11 after readout");
    read_both("R11 acc kept");

    idle(4'd0, 32'h0, 32'h0);
    repeat (3) @(negedge clk);
    check(sbq.size() == 0, "R5 all results seen", 32'(sbq.size()), 32'h0);
    summary();
    $finish;
  end

endmodule